// File: doc/BRIEF.md
# Register-Bank Context Switch Unit

This unit carries out a software context switch without touching a stack. A trap strobe comes with a bank operand that picks one of several register banks. The unit parks the caller's status word and program counter in register pairs of that bank and makes the bank active. It clears the interrupt enable and the register-set select flag. It then loads the program counter with a handler entry address that was left in the bank earlier. The upper program-counter bits are forced to zero, so every handler starts in the base area.

A companion return strobe undoes the switch. It reads the saved state from the bank that the current status word names. It restores the whole status word, which brings back the caller's bank select and interrupt enable, and rebuilds the program counter. It also stores the return operand in the bank as the handler entry address for the next switch. The unit drives write strobes to the external program-counter and status registers and uses a single-port register-file interface. The register file answers reads combinationally.

Top module: `ctxsw_unit`

## Requirements
- R1: After reset, `busy`, `done`, `pc_we`, `psw_we` and `rf_we` are all low.
- R2: A switch to bank n writes the status word with the bank-select field (bits 14:12) set to n, the interrupt-enable bit (bit 15) cleared and the register-set bit (bit 5) cleared. All other bits are kept.
- R3: A switch to bank n loads the program counter with zero in bits 19:16 and, in bits 15:0, the word held in pair code 0 (entry pair) of bank n.
- R4: A switch to bank n leaves the following in bank n. Pair code 0 holds the caller's PC[15:0]. Pair code 1 holds the caller's status word. Pair code 2 holds the caller's PC[19:16] in bits 11:8, with all other bits zero.
- R5: A return works on the bank given by bits 14:12 of the current status word. It loads the program counter with pair 2 bits 11:8 above pair 0, and the status word with pair 1. It writes the return operand into pair 0.
- R6: Each operation makes at most one register-file write per clock. `done` is high in the fourth clock after the cycle in which the strobe is accepted.
- R7: `done` lasts exactly one clock and falls within the `busy` interval. Exactly one `done` appears for each accepted strobe.
- R8: Switch and return strobes that arrive while `busy` is high are ignored. They do not change the outcome of the running operation.
- R9: When both strobes arrive together in idle, the switch is performed and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | Switch strobe |
| sw_bank | input | BANK_W | Target bank of the switch |
| ret_start | input | 1 | Return strobe |
| ret_addr | input | ADDR_W | Next handler entry address |
| cur_pc | input | PC_W | Present program counter |
| cur_psw | input | PSW_W | Present status word |
| pc_we | output | 1 | Program-counter write strobe |
| pc_wdata | output | PC_W | New program counter |
| psw_we | output | 1 | Status-word write strobe |
| psw_wdata | output | PSW_W | New status word |
| rf_we | output | 1 | Register-file write strobe |
| rf_bank | output | BANK_W | Register-file bank address |
| rf_pair | output | 2 | Register-pair code within the bank |
| rf_wdata | output | WORD_W | Register-file write data |
| rf_rdata | input | WORD_W | Register-file read data (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete, one clock |

## Verification
Switches are run to the lowest bank, the highest bank and a middle bank. This separates a correct use of the operand from one that uses a fixed or shifted index. A nested switch followed by two returns shows that the return reads the bank named by the status word and not the one last used. A repeated switch into the same bank shows that the return operand really became the next entry address. Strobes injected during an operation, and a switch and return raised together, show that the sequencer ignores late requests and gives the switch priority.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

   typedef enum logic [1:0] {
      PAIR_ENTRY = 2'd0,
      PAIR_PSW   = 2'd1,
      PAIR_PCHI  = 2'd2
   } pair_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_XCH,
      ST_SVPSW,
      ST_SVHI,
      ST_RPC,
      ST_RHI,
      ST_RPSW,
      ST_RWR
   } state_e;

endpackage

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
   import ctxsw_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sw_start,
   input  logic   ret_start,
   output state_e state,
   output logic   busy,
   output logic   done,
   output logic   ret_mode,
   output logic   take_sw,
   output logic   take_ret
);

   state_e state_d;

   assign take_sw  = (state == ST_IDLE) && sw_start;
   assign take_ret = (state == ST_IDLE) && ret_start && !sw_start;
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_SVHI) || (state == ST_RWR);
   assign ret_mode = (state == ST_RPC) || (state == ST_RHI) ||
                     (state == ST_RPSW) || (state == ST_RWR);

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE: begin
            if (take_sw)       state_d = ST_SEL;
            else if (take_ret) state_d = ST_RPC;
         end
         ST_SEL:   state_d = ST_XCH;
         ST_XCH:   state_d = ST_SVPSW;
         ST_SVPSW: state_d = ST_SVHI;
         ST_SVHI:  state_d = ST_IDLE;
         ST_RPC:   state_d = ST_RHI;
         ST_RHI:   state_d = ST_RPSW;
         ST_RPSW:  state_d = ST_RWR;
         ST_RWR:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end

endmodule

// File: rtl/ctxsw_psw_edit.sv
module ctxsw_psw_edit #(
   parameter int PSW_W   = 16,
   parameter int BANK_W  = 3,
   parameter int IE_POS  = 15,
   parameter int RBS_POS = 12,
   parameter int RSS_POS = 5,
   parameter bit HAS_RSS = 1'b1
) (
   input  logic [PSW_W-1:0]  psw_in,
   input  logic [BANK_W-1:0] bank,
   output logic [PSW_W-1:0]  psw_out
);

   logic [PSW_W-1:0] base;

   always_comb begin
      base                        = psw_in;
      base[IE_POS]                = 1'b0;
      base[RBS_POS +: BANK_W]     = bank;
   end

   generate
      if (HAS_RSS) begin : g_rss
         always_comb begin
            psw_out          = base;
            psw_out[RSS_POS] = 1'b0;
         end
      end else begin : g_no_rss
         assign psw_out = base;
      end
   endgenerate

endmodule

// File: rtl/ctxsw_hold.sv
module ctxsw_hold #(
   parameter int PC_W    = 20,
   parameter int ADDR_W  = 16,
   parameter int PSW_W   = 16,
   parameter int WORD_W  = 16,
   parameter int BANK_W  = 3,
   parameter int HI_POS  = 8,
   localparam int HI_W   = PC_W - ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_sw,
   input  logic              take_ret,
   input  logic [BANK_W-1:0] sw_bank,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic [PSW_W-1:0]  cur_psw,
   input  logic              ld_entry,
   input  logic              ld_hi,
   input  logic              ld_psw,
   input  logic [WORD_W-1:0] rf_rdata,
   output logic [BANK_W-1:0] bank_q,
   output logic [PSW_W-1:0]  psw_q,
   output logic [PC_W-1:0]   pc_q,
   output logic [ADDR_W-1:0] entry_q,
   output logic [HI_W-1:0]   rhi_q,
   output logic [ADDR_W-1:0] naddr_q,
   output logic [WORD_W-1:0] hi_word
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q  <= '0;
         psw_q   <= '0;
         pc_q    <= '0;
         entry_q <= '0;
         rhi_q   <= '0;
         naddr_q <= '0;
      end else begin
         if (take_sw || take_ret) begin
            bank_q  <= take_sw ? sw_bank : act_bank;
            psw_q   <= cur_psw;
            pc_q    <= cur_pc;
            naddr_q <= ret_addr;
         end
         if (ld_entry) entry_q <= rf_rdata[ADDR_W-1:0];
         if (ld_hi)    rhi_q   <= rf_rdata[HI_POS +: HI_W];
         if (ld_psw)   psw_q   <= rf_rdata[PSW_W-1:0];
      end
   end

   always_comb begin
      hi_word                  = '0;
      hi_word[HI_POS +: HI_W]  = pc_q[PC_W-1 -: HI_W];
   end

endmodule

// File: rtl/ctxsw_unit.sv
module ctxsw_unit
   import ctxsw_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int PC_W      = 20,
   parameter int ADDR_W    = 16,
   parameter int PSW_W     = 16,
   parameter int WORD_W    = 16,
   parameter int HI_POS    = 8,
   parameter int IE_POS    = 15,
   parameter int RBS_POS   = 12,
   parameter int RSS_POS   = 5,
   parameter bit HAS_RSS   = 1'b1,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int HI_W     = PC_W - ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_start,
   input  logic [BANK_W-1:0] sw_bank,
   input  logic              ret_start,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic [PC_W-1:0]   cur_pc,
   input  logic [PSW_W-1:0]  cur_psw,
   output logic              pc_we,
   output logic [PC_W-1:0]   pc_wdata,
   output logic              psw_we,
   output logic [PSW_W-1:0]  psw_wdata,
   output logic              rf_we,
   output logic [BANK_W-1:0] rf_bank,
   output logic [1:0]        rf_pair,
   output logic [WORD_W-1:0] rf_wdata,
   input  logic [WORD_W-1:0] rf_rdata,
   output logic              busy,
   output logic              done
);

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_chk_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (HI_W < 1) begin : g_chk_hi
         $error("PC_W must exceed ADDR_W");
      end
      if (ADDR_W > WORD_W || PSW_W > WORD_W || HI_POS + HI_W > WORD_W) begin : g_chk_word
         $error("register pair too narrow for saved state");
      end
      if (RBS_POS + BANK_W > PSW_W || IE_POS >= PSW_W || RSS_POS >= PSW_W) begin : g_chk_psw
         $error("status-word field outside PSW_W");
      end
   endgenerate

   state_e              state;
   logic                ret_mode;
   logic                take_sw;
   logic                take_ret;
   logic                ld_entry;
   logic                ld_hi;
   logic                ld_psw;
   logic [BANK_W-1:0]   bank_q;
   logic [PSW_W-1:0]    psw_q;
   logic [PC_W-1:0]     pc_q;
   logic [ADDR_W-1:0]   entry_q;
   logic [HI_W-1:0]     rhi_q;
   logic [ADDR_W-1:0]   naddr_q;
   logic [WORD_W-1:0]   hi_word;
   logic [PSW_W-1:0]    psw_sw;
   logic [WORD_W-1:0]   pclo_word;
   logic [WORD_W-1:0]   naddr_word;
   logic [WORD_W-1:0]   psw_word;

   ctxsw_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_start  (sw_start),
      .ret_start (ret_start),
      .state     (state),
      .busy      (busy),
      .done      (done),
      .ret_mode  (ret_mode),
      .take_sw   (take_sw),
      .take_ret  (take_ret)
   );

   ctxsw_hold #(
      .PC_W   (PC_W),
      .ADDR_W (ADDR_W),
      .PSW_W  (PSW_W),
      .WORD_W (WORD_W),
      .BANK_W (BANK_W),
      .HI_POS (HI_POS)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_sw  (take_sw),
      .take_ret (take_ret),
      .sw_bank  (sw_bank),
      .act_bank (cur_psw[RBS_POS +: BANK_W]),
      .ret_addr (ret_addr),
      .cur_pc   (cur_pc),
      .cur_psw  (cur_psw),
      .ld_entry (ld_entry),
      .ld_hi    (ld_hi),
      .ld_psw   (ld_psw),
      .rf_rdata (rf_rdata),
      .bank_q   (bank_q),
      .psw_q    (psw_q),
      .pc_q     (pc_q),
      .entry_q  (entry_q),
      .rhi_q    (rhi_q),
      .naddr_q  (naddr_q),
      .hi_word  (hi_word)
   );

   ctxsw_psw_edit #(
      .PSW_W   (PSW_W),
      .BANK_W  (BANK_W),
      .IE_POS  (IE_POS),
      .RBS_POS (RBS_POS),
      .RSS_POS (RSS_POS),
      .HAS_RSS (HAS_RSS)
   ) u_psw_edit (
      .psw_in  (psw_q),
      .bank    (bank_q),
      .psw_out (psw_sw)
   );

   always_comb begin
      pclo_word               = '0;
      pclo_word[ADDR_W-1:0]   = pc_q[ADDR_W-1:0];
      naddr_word              = '0;
      naddr_word[ADDR_W-1:0]  = naddr_q;
      psw_word                = '0;
      psw_word[PSW_W-1:0]     = psw_q;
   end

   always_comb begin
      pc_we     = 1'b0;
      pc_wdata  = '0;
      psw_we    = 1'b0;
      psw_wdata = '0;
      rf_we     = 1'b0;
      rf_bank   = bank_q;
      rf_pair   = PAIR_ENTRY;
      rf_wdata  = '0;
      ld_entry  = 1'b0;
      ld_hi     = 1'b0;
      ld_psw    = 1'b0;
      unique case (state)
         ST_SEL: begin
            psw_we    = 1'b1;
            psw_wdata = psw_sw;
            ld_entry  = 1'b1;
         end
         ST_XCH: begin
            rf_we     = 1'b1;
            rf_wdata  = pclo_word;
            pc_we     = 1'b1;
            pc_wdata  = {{HI_W{1'b0}}, entry_q};
         end
         ST_SVPSW: begin
            rf_we     = 1'b1;
            rf_pair   = PAIR_PSW;
            rf_wdata  = psw_word;
         end
         ST_SVHI: begin
            rf_we     = 1'b1;
            rf_pair   = PAIR_PCHI;
            rf_wdata  = hi_word;
         end
         ST_RPC: begin
            ld_entry  = 1'b1;
         end
         ST_RHI: begin
            rf_pair   = PAIR_PCHI;
            ld_hi     = 1'b1;
         end
         ST_RPSW: begin
            rf_pair   = PAIR_PSW;
            ld_psw    = 1'b1;
         end
         ST_RWR: begin
            rf_we     = 1'b1;
            rf_wdata  = naddr_word;
            pc_we     = 1'b1;
            pc_wdata  = {rhi_q, entry_q};
            psw_we    = 1'b1;
            psw_wdata = psw_q;
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/ctxsw_unit_chk.sv
module ctxsw_unit_chk #(
   parameter int PC_W    = 20,
   parameter int ADDR_W  = 16,
   parameter int PSW_W   = 16,
   parameter int BANK_W  = 3,
   parameter int IE_POS  = 15,
   parameter int RBS_POS = 12,
   parameter int RSS_POS = 5,
   parameter bit HAS_RSS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_start,
   input logic              ret_start,
   input logic              busy,
   input logic              done,
   input logic              ret_mode,
   input logic              pc_we,
   input logic [PC_W-1:0]   pc_wdata,
   input logic              psw_we,
   input logic [PSW_W-1:0]  psw_wdata,
   input logic              rf_we,
   input logic [BANK_W-1:0] rf_bank
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                               // R7

   AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);                                                // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(rf_we || pc_we || psw_we));                        // R6

   AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_start || ret_start) && !busy) |=> busy);                  // R7

   AST_SW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (psw_we && !ret_mode) |-> (!psw_wdata[IE_POS] &&
         (psw_wdata[RBS_POS +: BANK_W] == rf_bank) &&
         (!HAS_RSS || !psw_wdata[RSS_POS])));                        // R2

   AST_SW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_we && !ret_mode) |-> (pc_wdata[PC_W-1:ADDR_W] == '0));     // R3

   AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && $stable(rf_bank) && $stable(ret_mode))); // R8

endmodule

bind ctxsw_unit ctxsw_unit_chk #(
   .PC_W    (PC_W),
   .ADDR_W  (ADDR_W),
   .PSW_W   (PSW_W),
   .BANK_W  (BANK_W),
   .IE_POS  (IE_POS),
   .RBS_POS (RBS_POS),
   .RSS_POS (RSS_POS),
   .HAS_RSS (HAS_RSS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sw_start  (sw_start),
   .ret_start (ret_start),
   .busy      (busy),
   .done      (done),
   .ret_mode  (ret_mode),
   .pc_we     (pc_we),
   .pc_wdata  (pc_wdata),
   .psw_we    (psw_we),
   .psw_wdata (psw_wdata),
   .rf_we     (rf_we),
   .rf_bank   (rf_bank)
);

// File: tb/ctxsw_unit_bench.sv
module ctxsw_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_start = 1'b0;
   logic [2:0]  sw_bank = '0;
   logic        ret_start = 1'b0;
   logic [15:0] ret_addr = '0;
   logic [19:0] pc_m;
   logic [15:0] psw_m;
   logic        pc_we, psw_we, rf_we, busy, done;
   logic [19:0] pc_wdata;
   logic [15:0] psw_wdata, rf_wdata, rf_rdata;
   logic [2:0]  rf_bank;
   logic [1:0]  rf_pair;
   logic [15:0] mem [8][3];

   int checks = 0;
   int errors = 0;
   int pushes = 0;
   int dones  = 0;
   bit ended  = 1'b0;

   typedef struct {
      int          kind;
      logic [19:0] pc;
      logic [15:0] psw;
      int          bk;
      logic [15:0] w0, w1, w2;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;

   ctxsw_unit u_ctxsw_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_start  (sw_start),
      .sw_bank   (sw_bank),
      .ret_start (ret_start),
      .ret_addr  (ret_addr),
      .cur_pc    (pc_m),
      .cur_psw   (psw_m),
      .pc_we     (pc_we),
      .pc_wdata  (pc_wdata),
      .psw_we    (psw_we),
      .psw_wdata (psw_wdata),
      .rf_we     (rf_we),
      .rf_bank   (rf_bank),
      .rf_pair   (rf_pair),
      .rf_wdata  (rf_wdata),
      .rf_rdata  (rf_rdata),
      .busy      (busy),
      .done      (done)
   );

   // Model of the external PC, status word and register banks
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_m  <= 20'hA1234;
         psw_m <= 16'h902A;
         for (int b = 0; b < 8; b++) begin
            mem[b][0] <= 16'h4000 + 16'(b * 16'h0123);
            mem[b][1] <= '0;
            mem[b][2] <= '0;
         end
      end else begin
         if (pc_we)  pc_m  <= pc_wdata;
         if (psw_we) psw_m <= psw_wdata;
         if (rf_we && rf_pair != 2'd3) mem[rf_bank][rf_pair] <= rf_wdata;
      end
   end

   assign rf_rdata = (rf_pair != 2'd3) ? mem[rf_bank][rf_pair] : 16'h0000;

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input int kind, input string sw_tag);
      if (kind == 1) return "R5";
      if (kind == 2) return "R8";
      if (kind == 3) return "R9";
      return sw_tag;
   endfunction

   // Monitor: pops an expected item for each done and compares the committed state
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            dones++;
            @(posedge clk);
            #1;
            check(!done, "R7 done one clock", 32'(done), 32'd0);
            if (q.size() == 0) begin
               check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(pc_m == e.pc, tag_of(e.kind, "R3 pc"), 32'(pc_m), 32'(e.pc));
               check(psw_m == e.psw, tag_of(e.kind, "R2 psw"), 32'(psw_m), 32'(e.psw));
               check(mem[e.bk][0] == e.w0, tag_of(e.kind, "R4 entry pair"),
                     32'(mem[e.bk][0]), 32'(e.w0));
               check(mem[e.bk][1] == e.w1, tag_of(e.kind, "R4 psw pair"),
                     32'(mem[e.bk][1]), 32'(e.w1));
               check(mem[e.bk][2] == e.w2, tag_of(e.kind, "R4 pc-high pair"),
                     32'(mem[e.bk][2]), 32'(e.w2));
            end
         end
      end
   end

   task automatic wait_op(input bit noise);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k == 1) begin
            sw_start  = 1'b0;
            ret_start = 1'b0;
         end
         if (noise && k == 2) begin
            sw_start  = 1'b1;
            sw_bank   = 3'd1;
            ret_start = 1'b1;
            ret_addr  = 16'hBEEF;
         end
         if (noise && k == 3) begin
            sw_start  = 1'b0;
            ret_start = 1'b0;
         end
         check(busy, "R7 busy during operation", 32'(busy), 32'd1);
         check(done == (k == 4), "R6 done in fourth cycle", 32'(done), 32'(k == 4));
      end
   endtask

   task automatic do_switch(input int n, input int kind);
      exp_t e;
      @(negedge clk);
      e.kind = kind;
      e.bk   = n;
      e.pc   = {4'h0, mem[n][0]};
      e.psw  = (psw_m & ~16'hF020) | 16'(n << 12);
      e.w0   = pc_m[15:0];
      e.w1   = psw_m;
      e.w2   = {4'h0, pc_m[19:16], 8'h00};
      q.push_back(e);
      pushes++;
      sw_start = 1'b1;
      sw_bank  = 3'(n);
      if (kind == 3) begin
         ret_start = 1'b1;
         ret_addr  = 16'hDEAD;
      end
      wait_op(kind == 2);
   endtask

   task automatic do_return(input logic [15:0] addr, input int kind);
      exp_t e;
      int b;
      @(negedge clk);
      b      = int'(psw_m[14:12]);
      e.kind = kind;
      e.bk   = b;
      e.pc   = {mem[b][2][11:8], mem[b][0]};
      e.psw  = mem[b][1];
      e.w0   = addr;
      e.w1   = mem[b][1];
      e.w2   = mem[b][2];
      q.push_back(e);
      pushes++;
      ret_start = 1'b1;
      ret_addr  = addr;
      wait_op(kind == 2);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!busy && !done, "R1 busy/done after reset", {30'd0, busy, done}, 32'd0);
      check(!pc_we && !psw_we && !rf_we, "R1 write strobes after reset",
            {29'd0, pc_we, psw_we, rf_we}, 32'd0);

      do_switch(3, 0);            // middle bank
      do_return(16'h2222, 1);     // back to caller, new entry for bank 3
      do_switch(3, 0);            // entry must now be 2222
      do_switch(5, 0);            // nested switch from bank 3
      do_return(16'h5555, 1);     // returns into bank 3 context
      do_return(16'h3333, 1);     // returns to original caller
      do_switch(0, 0);            // lowest bank
      do_switch(7, 2);            // highest bank with late strobes (R8)
      do_return(16'h7777, 2);     // return with late strobes (R8)
      do_switch(6, 3);            // both strobes together (R9)

      repeat (4) @(negedge clk);
      check(q.size() == 0, "R7 every operation completed", 32'(q.size()), 32'd0);
      check(dones == pushes, "R7 one done per accepted strobe", 32'(dones), 32'(pushes));
      check(!busy, "R8 idle after late strobes", 32'(busy), 32'd0);
      finish_run();
   end

endmodule